// File: doc/BRIEF.md
# Escape-Qualified Control Code Filter

This block sits on the host-to-terminal character path and decides, once per received character, whether the character is written into display memory as data or triggers an edit or cursor function. Ten control codes have such a function: cancel, device control 1 and 3, carriage return, form feed, vertical tab, horizontal tab, backspace, end of text and escape. A host that needs one of them stored literally sends an escape code first.

The block keeps a one-character escape latch. If the latch is set, the next character is always stored and never executed, and the latch then clears. If the latch is clear, a qualified code is executed and not stored, and any other character is stored. An escape that arrives with the latch clear sets the latch and produces no output. Characters count only while receive mode is asserted, and leaving receive mode clears the latch. Each result appears on the registered outputs one clock after the strobe and lasts one cycle.

Top module: `esc_ctl_filter`

## Requirements
- R1: After reset, store_o and exec_o are low and the escape latch is clear.
- R2: With the latch clear, a qualified code (0x18, 0x13, 0x11, 0x0D, 0x0C, 0x0B, 0x09, 0x08, 0x03) pulses exec_o one cycle after the strobe, with exec_chr_o equal to the code, and store_o stays low.
- R3: With the latch set, a qualified code pulses store_o one cycle after the strobe, with store_chr_o equal to the code, and exec_o stays low.
- R4: With the latch clear, an escape (0x1B) produces neither store_o nor exec_o and sets the latch.
- R5: An escape that arrives with the latch set is stored, and the latch clears.
- R6: Any character that arrives with the latch set clears the latch. A non-qualified character is stored as usual.
- R7: With the latch clear, a character that is neither qualified nor escape is stored and not executed.
- R8: A strobe while receive mode is low has no effect on the outputs or on the latch.
- R9: Leaving receive mode clears the latch.
- R10: store_o and exec_o are never high in the same cycle, and both are low in any cycle that does not follow an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_mode_i | input | 1 | Terminal is in receive mode |
| chr_vld_i | input | 1 | One-cycle strobe that marks a character |
| chr_i | input | 7 | Received character |
| store_o | output | 1 | Write the character to display memory |
| store_chr_o | output | 7 | Character to write |
| exec_o | output | 1 | Perform the control function |
| exec_chr_o | output | 7 | Control code to perform |

## Verification
The assertions assume that chr_i is stable and known whenever chr_vld_i and rx_mode_i are both high. They also assume a strobe lasts exactly one cycle per character, so every accepted cycle is a new character. The stimulus drives a fresh character with each strobe, and it inserts idle cycles and receive-mode drops at random. Characters are drawn with a strong bias toward the qualified codes and toward escape, so that escape pairs and escape-then-data sequences occur often next to plain printable data.

// File: rtl/esc_filt_pkg.sv
package esc_filt_pkg;
  localparam int unsigned CHAR_W   = 7;
  localparam int unsigned NUM_QUAL = 9;
  typedef logic [CHAR_W-1:0] chr_t;

  localparam chr_t ESC_CODE = 7'h1B;
  // codes whose function is suppressed after escape (escape handled apart)
  localparam chr_t QUAL_CODES [NUM_QUAL] = '{
    7'h18, 7'h13, 7'h11, 7'h0D, 7'h0C, 7'h0B, 7'h09, 7'h08, 7'h03
  };
endpackage

// File: rtl/esc_code_decode.sv
module esc_code_decode
  import esc_filt_pkg::*;
(
  input  chr_t chr_i,
  output logic qual_o,
  output logic is_esc_o
);
  logic [NUM_QUAL-1:0] hit;

  for (genvar g = 0; g < NUM_QUAL; g++) begin : g_cmp
    assign hit[g] = (chr_i == QUAL_CODES[g]);
  end

  assign qual_o   = |hit;
  assign is_esc_o = (chr_i == ESC_CODE);
endmodule

// File: rtl/esc_latch.sv
module esc_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_mode_i,
  input  logic fire_i,
  input  logic is_esc_i,
  output logic esc_o
);
  logic esc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         esc_q <= 1'b0;
    else if (!rx_mode_i) esc_q <= 1'b0;
    else if (fire_i)     esc_q <= esc_q ? 1'b0 : is_esc_i;
  end

  assign esc_o = esc_q;

  p_esc_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !esc_q && is_esc_i) |=> esc_q);
  p_esc_one_char_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && esc_q) |=> !esc_q);
  p_rx_exit_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_mode_i |=> !esc_q);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_mode_i && !fire_i) |=> $stable(esc_q));
endmodule

// File: rtl/esc_route.sv
module esc_route
  import esc_filt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic esc_i,
  input  logic qual_i,
  input  logic is_esc_i,
  input  chr_t chr_i,
  output logic store_o,
  output chr_t store_chr_o,
  output logic exec_o,
  output chr_t exec_chr_o
);
  logic store_d, exec_d;
  chr_t chr_q;

  always_comb begin
    store_d = 1'b0;
    exec_d  = 1'b0;
    if (fire_i) begin
      if (esc_i)         store_d = 1'b1;
      else if (is_esc_i) store_d = 1'b0;
      else if (qual_i)   exec_d  = 1'b1;
      else               store_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o <= 1'b0;
      exec_o  <= 1'b0;
      chr_q   <= '0;
    end else begin
      store_o <= store_d;
      exec_o  <= exec_d;
      if (fire_i) chr_q <= chr_i;
    end
  end

  assign store_chr_o = chr_q;
  assign exec_chr_o  = chr_q;

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_o && exec_o));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> (!store_o && !exec_o));
  p_after_esc_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && esc_i) |=> (store_o && !exec_o && store_chr_o == $past(chr_i)));
  p_qual_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !esc_i && qual_i) |=> (exec_o && !store_o && exec_chr_o == $past(chr_i)));
  p_data_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !esc_i && !qual_i && !is_esc_i) |=> (store_o && !exec_o));
endmodule

// File: rtl/esc_ctl_filter.sv
module esc_ctl_filter
  import esc_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_mode_i,
  input  logic              chr_vld_i,
  input  logic [CHAR_W-1:0] chr_i,
  output logic              store_o,
  output logic [CHAR_W-1:0] store_chr_o,
  output logic              exec_o,
  output logic [CHAR_W-1:0] exec_chr_o
);
  logic fire, qual, is_esc, esc_q;

  assign fire = rx_mode_i & chr_vld_i;

  esc_code_decode u_dec (
    .chr_i   (chr_i),
    .qual_o  (qual),
    .is_esc_o(is_esc)
  );

  esc_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_mode_i(rx_mode_i),
    .fire_i   (fire),
    .is_esc_i (is_esc),
    .esc_o    (esc_q)
  );

  esc_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .esc_i      (esc_q),
    .qual_i     (qual),
    .is_esc_i   (is_esc),
    .chr_i      (chr_i),
    .store_o    (store_o),
    .store_chr_o(store_chr_o),
    .exec_o     (exec_o),
    .exec_chr_o (exec_chr_o)
  );

  p_esc_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && esc_q && is_esc) |=> (store_o && store_chr_o == ESC_CODE && !esc_q));
  p_lone_esc_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !esc_q && is_esc) |=> (!store_o && !exec_o));
endmodule

// File: tb/tb_esc_ctl_filter.sv
module tb_esc_ctl_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_mode = 1'b0;
  logic       vld = 1'b0;
  logic [6:0] chr = '0;
  logic       store, exec;
  logic [6:0] store_chr, exec_chr;

  int total = 0;
  int bad = 0;
  bit esc_m = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  esc_ctl_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_mode_i(rx_mode), .chr_vld_i(vld),
    .chr_i(chr), .store_o(store), .store_chr_o(store_chr),
    .exec_o(exec), .exec_chr_o(exec_chr)
  );

  function automatic bit is_qual(logic [6:0] c);
    return c inside {7'h18, 7'h13, 7'h11, 7'h0D, 7'h0C, 7'h0B, 7'h09, 7'h08, 7'h03};
  endfunction

  task automatic check(string req, bit cond, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check registered result at next negedge
  task automatic step(bit rx, bit v, logic [6:0] c, string req);
    bit e_st, e_ex, acc;
    acc = rx && v;
    e_st = 1'b0; e_ex = 1'b0;
    if (acc) begin
      if (esc_m)            e_st = 1'b1;
      else if (c == 7'h1B)  e_st = 1'b0;
      else if (is_qual(c))  e_ex = 1'b1;
      else                  e_st = 1'b1;
    end
    rx_mode = rx; vld = v; chr = c;
    @(negedge clk);
    vld = 1'b0;
    if (!rx)      esc_m = 1'b0;
    else if (acc) esc_m = esc_m ? 1'b0 : (c == 7'h1B);
    check(req, store == e_st, "store", store, e_st);
    check(req, exec == e_ex, "exec", exec, e_ex);
    if (e_st) check(req, store_chr == c, "store_chr", store_chr, c);
    if (e_ex) check(req, exec_chr == c, "exec_chr", exec_chr, c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", store == 0, "store", store, 0);
    check("R1", exec == 0, "exec", exec, 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 1, 7'h0D, "R2");            // R1 latch clear: CR executes
    step(1, 1, 7'h1B, "R4");            // lone ESC
    step(1, 1, 7'h0D, "R3");            // stored
    step(1, 1, 7'h03, "R2");            // latch cleared
    step(1, 1, 7'h1B, "R4");
    step(1, 1, 7'h1B, "R5");            // ESC ESC stored
    step(1, 1, 7'h08, "R5");            // latch cleared: BS executes
    step(1, 1, 7'h1B, "R4");
    step(1, 1, 7'h41, "R6");            // printable stored, latch drops
    step(1, 1, 7'h09, "R6");            // HT executes
    step(1, 1, 7'h5A, "R7");
    step(1, 1, 7'h01, "R7");            // unlisted control stored
    step(0, 1, 7'h1B, "R8");            // ignored
    step(1, 1, 7'h0C, "R8");            // ESC not latched: FF executes
    step(1, 1, 7'h1B, "R4");
    step(1, 0, 7'h00, "R10");           // idle, latch held
    step(1, 1, 7'h18, "R3");
    step(1, 1, 7'h1B, "R4");
    step(0, 0, 7'h00, "R9");            // leave rx mode
    step(1, 1, 7'h13, "R9");            // DC3 executes, latch gone
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] c;
      bit rx, v;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: c = 7'h1B;
        3, 4, 5: begin
          int k;
          k = $urandom_range(0, 8);
          case (k)
            0: c = 7'h18; 1: c = 7'h13; 2: c = 7'h11; 3: c = 7'h0D; 4: c = 7'h0C;
            5: c = 7'h0B; 6: c = 7'h09; 7: c = 7'h08; default: c = 7'h03;
          endcase
        end
        default: c = 7'($urandom_range(0, 127));
      endcase
      rx = ($urandom_range(0, 15) != 0);
      v  = ($urandom_range(0, 4) != 0);
      step(rx, v, c, "R10");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule